// File: doc/BRIEF.md
# Clock Synthesizer Power-Up Sequencer

This block steps a clock synthesizer from power-off to running outputs. It runs on a free-running timing clock. It watches two inputs: a flag saying the analog supply is good, and an active-low external power-good input. When the supply flag is seen, the block turns the VCO on and arms itself. On the first low level of power-good it captures the two frequency-select strap inputs, and it never samples them again while the supply stays up. It then waits through two fixed delays and enables the clock outputs.

Both delays are given in nanoseconds and converted to cycle counts from a clock-frequency parameter, rounding up. The supply flag, the power-good input and the straps each pass through a two-flop synchronizer before the state machine sees them. Losing the supply flag sends the block back to power-off from any phase. The reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `clkgen_pwrup_seq`

## Requirements
- R1: While reset is held low, the block shows phase 0 (off), `freq_code_o` = 0, `vco_en_o` = 0 and `out_en_o` = 0.
- R2: In phase 0 the block ignores power-good and stays off until `supply_ok_i` is seen high. Three cycles after `supply_ok_i` rises, it is in phase 1 (armed). `vco_en_o` is 1 in every phase except phase 0.
- R3: In phase 1, the first cycle in which synchronized `pwrgd_ni` is low captures `strap_i` into `freq_code_o`, bit for bit. A high level on `pwrgd_ni` changes nothing.
- R4: After the capture edge, the block stays in phase 1 for ceil(SETTLE_NS × CLK_HZ / 1e9) cycles (at least 1) and then enters phase 2 (warm-up).
- R5: Phase 2 lasts ceil(ENABLE_NS × CLK_HZ / 1e9) cycles (at least 1), after which the block enters phase 3 (run). `out_en_o` is 1 in phase 3 and 0 in every other phase.
- R6: Once the straps are captured, later toggles of `pwrgd_ni` and changes on `strap_i` have no effect on the phase, `freq_code_o` or `out_en_o`.
- R7: `supply_ok_i` going low in any phase brings the block to phase 0 three cycles later, with `vco_en_o`, `out_en_o` and `freq_code_o` all 0.
- R8: If `pwrgd_ni` is already low when the supply comes up, the capture happens on the first cycle in phase 1, one cycle after phase 1 is entered.
- R9: Driving `rst_ni` low forces phase 0 and clears all outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Analog supply above threshold |
| pwrgd_ni | input | 1 | External power-good, active low |
| strap_i | input | SEL_W | Frequency-select strap inputs |
| freq_code_o | output | SEL_W | Captured frequency-select code |
| vco_en_o | output | 1 | VCO enable |
| out_en_o | output | 1 | Clock output enable |
| phase_o | output | 2 | Sequencer phase: 0 off, 1 armed, 2 warm-up, 3 run |

## Verification
The bench runs the sequence in several ways. In the first, power-good falls well after the block arms. This timestamps both delays against the capture edge, and any wrong counter length shows up as a transition in the wrong cycle. In a second run, power-good is already low before the supply comes up, which exposes the one-cycle difference of capturing on arrival. Power-good and the straps are toggled during the settle delay, during warm-up and during run. Any spurious phase change or code change there shows that capture was not one-shot. Supply loss is applied both in run and in the middle of the settle delay, and a reset is applied in run, to show that the block returns to off from different phases.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_ARM  = 2'd1,
    PH_WARM = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  // Cycles needed to cover a delay in ns at a clock of hz, rounded up.
  function automatic longint unsigned cycles_for_ns(longint unsigned ns,
                                                    longint unsigned hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_no = chain_q[1];
endmodule

// File: rtl/pwrup_sync.sv
module pwrup_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SHORT_CYC = 4,
  parameter int unsigned LONG_CYC  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = long_i ? LONG_LD : SHORT_LD;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // An expired timer stays expired until it is reloaded.
  assert_done_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);

  // A loaded timer is busy on the next cycle unless its length is one.
  assert_load_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && long_i && (LONG_CYC > 1)) |=> !done_o);
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             pwrgd_ni,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic             tmr_long_o,
  output logic [1:0]       phase_o,
  output logic [SEL_W-1:0] code_o,
  output logic             vco_en_o,
  output logic             out_en_o
);
  phase_e           state_q, state_d;
  logic             held_q, held_d;
  logic [SEL_W-1:0] code_q, code_d;
  logic             code_we;

  always_comb begin
    state_d    = state_q;
    held_d     = held_q;
    code_d     = code_q;
    code_we    = 1'b0;
    tmr_load_o = 1'b0;
    tmr_long_o = 1'b0;
    unique case (state_q)
      PH_OFF: begin
        held_d  = 1'b0;
        code_d  = '0;
        code_we = 1'b1;
        if (supply_ok_i) state_d = PH_ARM;
      end
      PH_ARM: begin
        if (!held_q && !pwrgd_ni) begin
          held_d     = 1'b1;
          code_d     = strap_i;
          code_we    = 1'b1;
          tmr_load_o = 1'b1;
        end else if (held_q && tmr_done_i) begin
          state_d    = PH_WARM;
          tmr_load_o = 1'b1;
          tmr_long_o = 1'b1;
        end
      end
      PH_WARM: begin
        if (tmr_done_i) state_d = PH_RUN;
      end
      PH_RUN: begin
      end
      default: state_d = PH_OFF;
    endcase
    if (!supply_ok_i) begin
      state_d    = PH_OFF;
      held_d     = 1'b0;
      code_d     = '0;
      code_we    = 1'b1;
      tmr_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_OFF;
      held_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      held_q  <= held_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (code_we) code_q <= code_d;
  end

  assign phase_o  = state_q;
  assign code_o   = code_q;
  assign vco_en_o = (state_q != PH_OFF);
  assign out_en_o = (state_q == PH_RUN);

  assert_stay_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_OFF && !supply_ok_i) |=> state_q == PH_OFF);

  assert_capture_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_ARM && held_q && supply_ok_i) |=> $stable(code_q));

  assert_warm_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_WARM && !tmr_done_i && supply_ok_i) |=> state_q == PH_WARM);

  assert_code_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == PH_WARM || state_q == PH_RUN) && supply_ok_i) |=> $stable(code_q));

  assert_supply_loss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_q == PH_OFF && code_q == '0));
endmodule

// File: rtl/clkgen_pwrup_seq.sv
module clkgen_pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 14_318_180,
  parameter int unsigned SETTLE_NS = 250_000,
  parameter int unsigned ENABLE_NS = 1_146_000,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             pwrgd_ni,
  input  logic [SEL_W-1:0] strap_i,
  output logic [SEL_W-1:0] freq_code_o,
  output logic             vco_en_o,
  output logic             out_en_o,
  output logic [1:0]       phase_o
);
  localparam longint unsigned SETTLE_RAW = cycles_for_ns(64'(SETTLE_NS), 64'(CLK_HZ));
  localparam longint unsigned ENABLE_RAW = cycles_for_ns(64'(ENABLE_NS), 64'(CLK_HZ));
  localparam int unsigned SETTLE_CYC = (SETTLE_RAW < 64'd1) ? 1 : 32'(SETTLE_RAW);
  localparam int unsigned ENABLE_CYC = (ENABLE_RAW < 64'd1) ? 1 : 32'(ENABLE_RAW);
  localparam int unsigned MAX_CYC    = (SETTLE_CYC > ENABLE_CYC) ? SETTLE_CYC : ENABLE_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
  localparam int unsigned SYNC_W     = SEL_W + 2;
  // Supply flag idles low, power-good idles high (inactive), straps idle low.
  localparam logic [SYNC_W-1:0] SYNC_RST = {{SEL_W{1'b0}}, 1'b1, 1'b0};

  logic              rst_n_int;
  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              tmr_load, tmr_long, tmr_done;

  pwrup_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  assign raw_in = {strap_i, pwrgd_ni, supply_ok_i};

  pwrup_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (raw_in),
    .q_o    (sync_out)
  );

  pwrup_timer #(.CNT_W(CNT_W), .SHORT_CYC(SETTLE_CYC), .LONG_CYC(ENABLE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .load_i (tmr_load),
    .long_i (tmr_long),
    .done_o (tmr_done)
  );

  pwrup_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .supply_ok_i (sync_out[0]),
    .pwrgd_ni    (sync_out[1]),
    .strap_i     (sync_out[SYNC_W-1:2]),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_long_o  (tmr_long),
    .phase_o     (phase_o),
    .code_o      (freq_code_o),
    .vco_en_o    (vco_en_o),
    .out_en_o    (out_en_o)
  );

  assert_oe_has_vco_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    out_en_o |-> vco_en_o);
endmodule

// File: tb/clkgen_pwrup_seq_bench.sv
module clkgen_pwrup_seq_bench;
  localparam int unsigned CLK_HZ    = 1_000_000;
  localparam int unsigned SETTLE_NS = 250_000;
  localparam int unsigned ENABLE_NS = 1_146_000;
  localparam time         CLK_PERIOD = 1000ns;
  localparam longint unsigned N_SET =
    (64'(SETTLE_NS) * 64'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint unsigned N_ENA =
    (64'(ENABLE_NS) * 64'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int NS = int'(N_SET);
  localparam int NE = int'(N_ENA);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       pwrgd_n;
  logic [1:0] strap;
  logic [1:0] freq_code;
  logic       vco_en, out_en;
  logic [1:0] phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [1:0] prev_phase;

  int         q_cyc[$];
  logic [1:0] q_ph[$];
  logic [1:0] q_code[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkgen_pwrup_seq #(.CLK_HZ(CLK_HZ), .SETTLE_NS(SETTLE_NS),
                     .ENABLE_NS(ENABLE_NS), .SEL_W(2)) u_clkgen_pwrup_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .supply_ok_i (supply_ok),
    .pwrgd_ni    (pwrgd_n),
    .strap_i     (strap),
    .freq_code_o (freq_code),
    .vco_en_o    (vco_en),
    .out_en_o    (out_en),
    .phase_o     (phase)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic expect_tr(int at, logic [1:0] ph, logic [1:0] cd, string tag);
    q_cyc.push_back(at);
    q_ph.push_back(ph);
    q_code.push_back(cd);
    q_tag.push_back(tag);
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outs(string tag, int ph, int cd, int vco, int oe);
    chk(phase == 2'(ph), tag, "phase", int'(phase), ph);
    chk(freq_code == 2'(cd), tag, "freq_code", int'(freq_code), cd);
    chk(vco_en == 1'(vco), tag, "vco_en", int'(vco_en), vco);
    chk(out_en == 1'(oe), tag, "out_en", int'(out_en), oe);
  endtask

  task automatic jiggle(int n);
    for (int i = 0; i < n; i++) begin
      pwrgd_n = ~pwrgd_n;
      strap   = strap + 2'd1;
      @(negedge clk);
    end
  endtask

  // Monitor: pops an expected item whenever the phase output changes.
  always @(negedge clk) begin
    if (mon_on) begin
      chk(out_en == (phase == 2'd3), "R5", "out_en vs phase", int'(out_en), int'(phase == 2'd3));
      chk(vco_en == (phase != 2'd0), "R2", "vco_en vs phase", int'(vco_en), int'(phase != 2'd0));
      if (phase !== prev_phase) begin
        if (q_cyc.size() == 0) begin
          chk(1'b0, "R6", "unexpected phase change", int'(phase), int'(prev_phase));
        end else begin
          int         ec;
          logic [1:0] ep, ed;
          string      et;
          ec = q_cyc.pop_front();
          ep = q_ph.pop_front();
          ed = q_code.pop_front();
          et = q_tag.pop_front();
          chk(cyc == ec, et, "transition cycle", cyc, ec);
          chk(phase == ep, et, "new phase", int'(phase), int'(ep));
          chk(freq_code == ed, et, "code at transition", int'(freq_code), int'(ed));
        end
      end
      prev_phase = phase;
    end
  end

  initial begin
    #(CLK_PERIOD * 50_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; supply_ok = 1'b0; pwrgd_n = 1'b1; strap = 2'b00;
    idle(3);
    check_outs("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    idle(6);
    prev_phase = phase;
    mon_on = 1'b1;

    // R2: power-good activity with supply off does nothing
    jiggle(20);
    pwrgd_n = 1'b1; strap = 2'b10;
    idle(5);
    check_outs("R2", 0, 0, 0, 0);

    // R2: supply up, block arms
    c = cyc; supply_ok = 1'b1;
    expect_tr(c + 3, 2'd1, 2'd0, "R2");
    idle(20);
    check_outs("R2", 1, 0, 1, 0);

    // R3/R4/R5: power-good falls, straps 10 captured
    c = cyc; pwrgd_n = 1'b0;
    expect_tr(c + 3 + NS, 2'd2, 2'b10, "R4");
    expect_tr(c + 3 + NS + NE, 2'd3, 2'b10, "R5");
    idle(5);
    check_outs("R3", 1, 2, 1, 0);
    jiggle(60);                       // R6: during settle delay
    pwrgd_n = 1'b1;
    wait_until(c + 3 + NS + 10);
    check_outs("R6", 2, 2, 1, 0);
    jiggle(100);                      // R6: during warm-up
    wait_until(c + 3 + NS + NE + 20);
    check_outs("R5", 3, 2, 1, 1);
    jiggle(40);                       // R6: during run
    idle(5);
    check_outs("R6", 3, 2, 1, 1);

    // R7: supply loss in run
    c = cyc; supply_ok = 1'b0;
    expect_tr(c + 3, 2'd0, 2'd0, "R7");
    idle(10);
    check_outs("R7", 0, 0, 0, 0);

    // R8: power-good already low before supply rises, straps 01
    pwrgd_n = 1'b0; strap = 2'b01;
    idle(5);
    c = cyc; supply_ok = 1'b1;
    expect_tr(c + 3, 2'd1, 2'd0, "R8");
    expect_tr(c + 4 + NS, 2'd2, 2'b01, "R8");
    expect_tr(c + 4 + NS + NE, 2'd3, 2'b01, "R8");
    wait_until(c + 4 + NS + NE + 5);
    check_outs("R8", 3, 1, 1, 1);

    // R9: asynchronous reset in run
    mon_on = 1'b0;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check_outs("R9", 0, 0, 0, 0);
    supply_ok = 1'b0; pwrgd_n = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    prev_phase = phase;
    mon_on = 1'b1;

    // R7: supply loss in the middle of the settle delay
    c = cyc; supply_ok = 1'b1;
    expect_tr(c + 3, 2'd1, 2'd0, "R7");
    idle(8);
    pwrgd_n = 1'b0; strap = 2'b11;
    idle(30);
    check_outs("R7", 1, 3, 1, 0);
    c = cyc; supply_ok = 1'b0;
    expect_tr(c + 3, 2'd0, 2'd0, "R7");
    idle(10);
    check_outs("R7", 0, 0, 0, 0);

    idle(10);
    chk(q_cyc.size() == 0, "R5", "pending transitions", q_cyc.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule